// File: doc/BRIEF.md
# Bus-Request Block Copy Engine

This block copies a block of bytes from one memory region to another on a shared processor bus that has a bus-request and bus-acknowledge handshake. The host first programs a source address, a destination address, a byte count and a mode word through a small write-only configuration port. A separate start write then launches the copy. The engine pulls its active-low request line and waits. It drives nothing onto the bus until the processor answers with an active-low acknowledge. It then moves one byte at a time: a read bus cycle at the source, followed by a write bus cycle at the destination. Each bus cycle is 2, 3 or 4 clocks long. When the count is used up, the engine drops its request and raises a sticky completion flag.

The memory behind the bus is dynamic and needs its rows visited regularly. Because the engine's own addresses run in sequence, every 128 bytes moved amount to a full row sweep. A deadline counter advances on each clock during which the engine owns the bus, and it clears whenever such a sweep completes. If the counter reaches its limit, the engine inserts a burst of 128 dedicated refresh cycles at the next byte boundary and then continues the copy. If the processor withdraws its acknowledge in the middle of a copy, the engine floats the bus at once. It later restarts the interrupted byte at the same addresses.

Top module: `dma_engine`

## Requirements
- R1: Configuration writes use select codes 0 for source address, 1 for destination address, 2 for byte count, 3 for mode and 4 for start. Any configuration write, start included, is ignored while a copy is in progress.
- R2: A start with a byte count of zero sets the completion flag on the clock edge that takes the start, and the bus request is never asserted.
- R3: A start with a non-zero count asserts the request on the clock edge that takes the start. Bus enable, address and all strobes stay inactive until the acknowledge input is low.
- R4: Mode bits [1:0] choose the bus cycle length: 00 gives 2 clocks, 01 gives 3, and 10 or 11 give 4. Each byte is an N-clock read at the source followed by an N-clock write at the destination. The address is held for the whole cycle, and the read or write strobe is low on every phase except the first.
- R5: In 2-clock mode, an uninterrupted copy of L bytes with no refresh owns the bus for exactly 4·L clocks.
- R6: Mode bit 2 selects the address direction: 0 increments both source and destination after each byte, and 1 decrements both.
- R7: After the last write phase, the request is released and the completion flag is set on the same edge. The flag stays set until the next accepted start with a non-zero count clears it.
- R8: While the acknowledge is high during a copy, the bus enable drops in the same cycle and all strobes are high, while the request stays asserted. Once the acknowledge returns, the interrupted byte restarts from its read at unchanged addresses, and the copied data ends up intact.
- R9: When owned-bus clocks since the last sweep or burst reach RFSH_DEADLINE, a burst begins at the next byte boundary. The burst is 128 consecutive refresh cycles, one per clock, with mreq_n_o and rfsh_n_o low, rd_n_o and wr_n_o high, and the address holding row 0 to 127 in order. The copy then resumes.
- R10: Every 128 bytes moved clear the deadline, so a copy that sweeps 128 bytes within the deadline inserts no refresh cycles, however long it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration select code |
| cfg_wdata_i | input | AW | Configuration write data |
| done_o | output | 1 | Sticky completion flag |
| busreq_n_o | output | 1 | Active-low bus request |
| busack_n_i | input | 1 | Active-low bus acknowledge |
| bus_oe_o | output | 1 | Engine drives the bus (low means floated) |
| addr_o | output | AW | Bus address |
| data_i | input | DW | Read data from memory |
| data_o | output | DW | Write data to memory |
| mreq_n_o | output | 1 | Active-low memory request |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| rfsh_n_o | output | 1 | Active-low refresh cycle marker |

## Verification
Most faults in the phase counter or sequencer state show up within one bus cycle, as a strobe on the wrong phase or an address change inside a cycle. They are caught the first time a single byte is moved in each of the three timing modes. A faulty address or count register is visible only through memory contents once the copy ends, so every scenario compares the whole destination region against the source pattern. Faults in the refresh tracker surface only after hundreds of owned clocks. The long runs therefore check the burst length, the row order, the earliest permitted burst position, and the absence of bursts when sweeps keep up.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_RFSH} dma_state_e;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_MODE = 3'd3;
  localparam logic [2:0] SEL_GO   = 3'd4;

  function automatic logic [2:0] cyc_len(input logic [1:0] tm);
    case (tm)
      2'b00:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg.sv
module dma_cfg import dma_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic [1:0]    tmode_o,
  output logic          desc_o,
  output logic          go_o
);
  logic acc;
  assign acc  = we_i && !busy_i;
  assign go_o = acc && (sel_i == SEL_GO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o   <= '0;
      dst_o   <= '0;
      cnt_o   <= '0;
      tmode_o <= 2'b01;
      desc_o  <= 1'b0;
    end else if (acc) begin
      case (sel_i)
        SEL_SRC:  src_o <= wdata_i;
        SEL_DST:  dst_o <= wdata_i;
        SEL_CNT:  cnt_o <= wdata_i[CW-1:0];
        SEL_MODE: begin
          tmode_o <= wdata_i[1:0];
          desc_o  <= wdata_i[2];
        end
        default: ;
      endcase
    end else if (step_i) begin
      src_o <= desc_o ? src_o - AW'(1) : src_o + AW'(1);
      dst_o <= desc_o ? dst_o - AW'(1) : dst_o + AW'(1);
      cnt_o <= cnt_o - CW'(1);
    end
  end

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_o != '0);
  assert_cfg_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o)));
endmodule

// File: rtl/dma_refresh.sv
module dma_refresh #(
  parameter int ROWS     = 128,
  parameter int DEADLINE = 7000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic active_i,
  input  logic byte_i,
  input  logic burst_done_i,
  output logic need_o
);
  localparam int DLW = $clog2(DEADLINE + 1);
  localparam int RW  = $clog2(ROWS);

  logic [DLW-1:0] dl_q;
  logic [RW-1:0]  run_q;
  logic           wrap;

  // a byte completing a full sweep cancels a pending burst
  assign wrap   = byte_i && (run_q == RW'(ROWS - 1));
  assign need_o = (dl_q >= DLW'(DEADLINE)) && !wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_q  <= '0;
      run_q <= '0;
    end else if (clr_i || burst_done_i || wrap) begin
      dl_q  <= '0;
      run_q <= '0;
    end else begin
      if (byte_i) run_q <= run_q + RW'(1);
      if (active_i && dl_q < DLW'(DEADLINE)) dl_q <= dl_q + DLW'(1);
    end
  end

  assert_need_after_deadline_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_o |-> !$past(clr_i));
endmodule

// File: rtl/dma_seq.sv
module dma_seq import dma_pkg::*; #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int ROWS = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    tmode_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          need_rfsh_i,
  input  logic          busack_n_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          step_o,
  output logic          burst_done_o,
  output logic          active_o,
  output logic          done_o,
  output logic          busreq_n_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          mreq_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          rfsh_n_o
);
  localparam int RW = $clog2(ROWS);

  dma_state_e    state_q;
  logic [1:0]    ph_q;
  logic [RW-1:0] row_q;
  logic [DW-1:0] dat_q;
  logic          done_q;
  logic          ack, on_bus, last, mid;
  logic [2:0]    len;

  assign len    = cyc_len(tmode_i);
  assign last   = ({1'b0, ph_q} == len - 3'd1);
  assign mid    = ph_q != 2'd0;
  assign ack    = !busack_n_i;
  assign on_bus = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_RFSH);

  assign bus_oe_o     = on_bus && ack;
  assign active_o     = bus_oe_o;
  assign busy_o       = state_q != ST_IDLE;
  assign busreq_n_o   = !busy_o;
  assign done_o       = done_q;
  assign step_o       = bus_oe_o && (state_q == ST_WR) && last;
  assign burst_done_o = bus_oe_o && (state_q == ST_RFSH) && (row_q == RW'(ROWS - 1));

  always_comb begin
    addr_o   = '0;
    data_o   = '0;
    mreq_n_o = 1'b1;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    rfsh_n_o = 1'b1;
    if (bus_oe_o) begin
      case (state_q)
        ST_RD: begin
          addr_o   = src_i;
          mreq_n_o = !mid;
          rd_n_o   = !mid;
        end
        ST_WR: begin
          addr_o   = dst_i;
          data_o   = dat_q;
          mreq_n_o = !mid;
          wr_n_o   = !mid;
        end
        ST_RFSH: begin
          addr_o   = {{(AW-RW){1'b0}}, row_q};
          mreq_n_o = 1'b0;
          rfsh_n_o = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      row_q   <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (go_i) begin
        if (cnt_i == '0) done_q <= 1'b1;
        else begin
          done_q  <= 1'b0;
          state_q <= ST_REQ;
        end
      end
    end else if (state_q == ST_REQ) begin
      ph_q <= '0;
      if (ack) state_q <= ST_RD;
    end else if (!ack) begin
      // lost the bus: restart the current byte later
      state_q <= ST_REQ;
      ph_q    <= '0;
    end else if (state_q == ST_RD) begin
      if (last) begin
        dat_q   <= data_i;
        ph_q    <= '0;
        state_q <= ST_WR;
      end else ph_q <= ph_q + 2'd1;
    end else if (state_q == ST_WR) begin
      if (last) begin
        ph_q <= '0;
        if (cnt_i == CW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else if (need_rfsh_i) begin
          state_q <= ST_RFSH;
          row_q   <= '0;
        end else state_q <= ST_RD;
      end else ph_q <= ph_q + 2'd1;
    end else begin
      row_q <= row_q + RW'(1);
      if (row_q == RW'(ROWS - 1)) state_q <= ST_RD;
    end
  end

  assert_quiet_without_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busack_n_i |-> (rd_n_o && wr_n_o && mreq_n_o && rfsh_n_o));
  assert_single_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  assert_addr_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && mid && ack && $past(ack)) |-> $stable(addr_o));
  assert_done_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busreq_n_o);
  assert_row_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RFSH && $past(state_q == ST_RFSH) && $past(ack) && ack)
      |-> row_q == $past(row_q) + RW'(1));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int CW            = 16,
  parameter int ROWS          = 128,
  parameter int RFSH_DEADLINE = 7000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          done_o,
  output logic          busreq_n_o,
  input  logic          busack_n_i,
  output logic          bus_oe_o,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          mreq_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          rfsh_n_o
);
  logic          busy, step, go, need, burst_done, active, desc;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [1:0]    tmode;

  dma_cfg #(.AW(AW), .CW(CW)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .busy_i(busy), .step_i(step), .src_o(src),
    .dst_o(dst), .cnt_o(cnt), .tmode_o(tmode), .desc_o(desc), .go_o(go)
  );

  dma_refresh #(.ROWS(ROWS), .DEADLINE(RFSH_DEADLINE)) u_refresh (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(go), .active_i(active),
    .byte_i(step), .burst_done_i(burst_done), .need_o(need)
  );

  dma_seq #(.AW(AW), .DW(DW), .CW(CW), .ROWS(ROWS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .cnt_i(cnt), .tmode_i(tmode),
    .src_i(src), .dst_i(dst), .need_rfsh_i(need), .busack_n_i(busack_n_i),
    .data_i(data_i), .busy_o(busy), .step_o(step), .burst_done_o(burst_done),
    .active_o(active), .done_o(done_o), .busreq_n_o(busreq_n_o),
    .bus_oe_o(bus_oe_o), .addr_o(addr_o), .data_o(data_o),
    .mreq_n_o(mreq_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .rfsh_n_o(rfsh_n_o)
  );

  // desc is consumed inside u_cfg; kept here for visibility of the mode
  logic unused_desc;
  assign unused_desc = desc;
endmodule

// File: tb/dma_engine_bench.sv
module dma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        done_o, busreq_n_o, bus_oe_o, mreq_n_o, rd_n_o, wr_n_o, rfsh_n_o;
  logic        busack_n = 1'b1;
  logic [15:0] addr_o;
  logic [7:0]  data_i, data_o;

  dma_engine #(.RFSH_DEADLINE(600)) u_dma_engine (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .done_o(done_o), .busreq_n_o(busreq_n_o),
    .busack_n_i(busack_n), .bus_oe_o(bus_oe_o), .addr_o(addr_o),
    .data_i(data_i), .data_o(data_o), .mreq_n_o(mreq_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .rfsh_n_o(rfsh_n_o)
  );

  always #10 clk = ~clk;

  logic [7:0] mem [0:4095];
  assign data_i = mem[addr_o[11:0]];
  always @(posedge clk)
    if (bus_oe_o && !mreq_n_o && !wr_n_o) mem[addr_o[11:0]] <= data_o;

  // processor model: grants three falling edges after a request unless held off
  bit hold = 1'b0;
  int ack_cnt = 0;
  always @(negedge clk) begin
    if (busreq_n_o || hold) begin
      busack_n <= 1'b1;
      ack_cnt  <= 0;
    end else if (ack_cnt == 2) busack_n <= 1'b0;
    else ack_cnt <= ack_cnt + 1;
  end

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ {4'h0, a[11:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic verify(input string req, input logic [15:0] src, input logic [15:0] dst,
                        input int len, input bit desc);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      logic [15:0] sa, da;
      sa = desc ? src - 16'(i) : src + 16'(i);
      da = desc ? dst - 16'(i) : dst + 16'(i);
      if (mem[da[11:0]] !== pat(sa)) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic run_copy(input logic [15:0] src, input logic [15:0] dst, input int len,
                          input logic [2:0] mode, output int owned, output int bursts,
                          output int first_rf, output int row_err);
    int row_exp = 0;
    bit in_b = 1'b0;
    owned = 0; bursts = 0; first_rf = -1; row_err = 0;
    for (int i = 0; i < len; i++) begin
      logic [15:0] sa, da;
      sa = mode[2] ? src - 16'(i) : src + 16'(i);
      da = mode[2] ? dst - 16'(i) : dst + 16'(i);
      mem[sa[11:0]] = pat(sa);
      mem[da[11:0]] = 8'h00;
    end
    cfg_wr(3'd0, src);
    cfg_wr(3'd1, dst);
    cfg_wr(3'd2, 16'(len));
    cfg_wr(3'd3, {13'd0, mode});
    cfg_wr(3'd4, 16'd0);
    chk("R3 request asserted after start", busreq_n_o, 0);
    chk("R7 done cleared by start", done_o, 0);
    for (int t = 0; t < 30000 && !done_o; t++) begin
      tick();
      if (bus_oe_o) begin
        if (!rfsh_n_o) begin
          if (!in_b) begin
            in_b = 1'b1; bursts++; row_exp = 0;
            if (first_rf < 0) first_rf = owned;
          end
          if (addr_o !== 16'(row_exp) || mreq_n_o !== 1'b0 || rd_n_o !== 1'b1 || wr_n_o !== 1'b1)
            row_err++;
          row_exp++;
        end else if (in_b) begin
          in_b = 1'b0;
          if (row_exp != 128) row_err++;
        end
        owned++;
      end
    end
    chk("R7 request released at end", busreq_n_o, 1);
  endtask

  task automatic t_reset();
    chk("R3 reset request idle", busreq_n_o, 1);
    chk("R3 reset bus floated", bus_oe_o, 0);
    chk("R3 reset strobes idle", {mreq_n_o, rd_n_o, wr_n_o, rfsh_n_o}, 4'hF);
    chk("R7 reset done clear", done_o, 0);
  endtask

  task automatic t_zero();
    bit req_seen = 1'b0;
    cfg_wr(3'd2, 16'd0);
    cfg_wr(3'd4, 16'd0);
    chk("R2 zero count done at once", done_o, 1);
    for (int i = 0; i < 6; i++) begin
      if (!busreq_n_o) req_seen = 1'b1;
      tick();
    end
    chk("R2 zero count never requests", req_seen, 0);
  endtask

  task automatic t_shape(input logic [1:0] tm, input int n, input string req);
    int bad = 0;
    mem[12'h100] = 8'hA5;
    mem[12'h200] = 8'h00;
    cfg_wr(3'd0, 16'h0100);
    cfg_wr(3'd1, 16'h0200);
    cfg_wr(3'd2, 16'd1);
    cfg_wr(3'd3, {14'd0, tm});
    cfg_wr(3'd4, 16'd0);
    chk("R7 done cleared by start", done_o, 0);
    chk("R3 no drive before ack", {bus_oe_o, mreq_n_o, rd_n_o, wr_n_o}, 4'b0111);
    for (int t = 0; t < 20 && !bus_oe_o; t++) tick();
    for (int k = 0; k < 2 * n; k++) begin
      if (k < n) begin
        if (addr_o !== 16'h0100 || rd_n_o !== (k == 0) || wr_n_o !== 1'b1 || mreq_n_o !== (k == 0)) bad++;
      end else begin
        if (addr_o !== 16'h0200 || wr_n_o !== (k == n) || rd_n_o !== 1'b1 || mreq_n_o !== (k == n)) bad++;
      end
      tick();
    end
    chk(req, bad, 0);
    chk("R7 done after last write", done_o, 1);
    chk("R7 request dropped after last write", busreq_n_o, 1);
    chk("R4 byte moved", int'(mem[12'h200]), 'hA5);
    repeat (3) tick();
    chk("R7 done stays set", done_o, 1);
  endtask

  task automatic t_rate();
    int o, b, f, r;
    run_copy(16'h0010, 16'h0310, 20, 3'b000, o, b, f, r);
    chk("R5 2-clock mode owns 4 clocks per byte", o, 80);
    verify("R6 ascending copy", 16'h0010, 16'h0310, 20, 1'b0);
  endtask

  task automatic t_desc();
    int o, b, f, r;
    run_copy(16'h03FF, 16'h07FF, 10, 3'b101, o, b, f, r);
    chk("R4 3-clock mode owns 6 clocks per byte", o, 60);
    verify("R6 descending copy", 16'h03FF, 16'h07FF, 10, 1'b1);
  endtask

  task automatic t_busy_ignore();
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      mem[12'h400 + 12'(i)] = pat(16'h0400 + 16'(i));
      mem[12'h500 + 12'(i)] = 8'h00;
      mem[12'h600 + 12'(i)] = 8'hEE;
    end
    cfg_wr(3'd0, 16'h0400);
    cfg_wr(3'd1, 16'h0500);
    cfg_wr(3'd2, 16'd8);
    cfg_wr(3'd3, 16'd2);
    cfg_wr(3'd4, 16'd0);
    for (int t = 0; t < 20 && !bus_oe_o; t++) tick();
    cfg_wr(3'd1, 16'h0600);
    cfg_wr(3'd2, 16'd1);
    for (int t = 0; t < 500 && !done_o; t++) tick();
    verify("R1 writes during copy ignored, full block lands", 16'h0400, 16'h0500, 8, 1'b0);
    for (int i = 0; i < 8; i++) if (mem[12'h600 + 12'(i)] !== 8'hEE) bad++;
    chk("R1 ignored destination untouched", bad, 0);
  endtask

  task automatic t_pause();
    int quiet_bad = 0;
    for (int i = 0; i < 12; i++) begin
      mem[12'h800 + 12'(i)] = pat(16'h0800 + 16'(i));
      mem[12'h900 + 12'(i)] = 8'h00;
    end
    cfg_wr(3'd0, 16'h0800);
    cfg_wr(3'd1, 16'h0900);
    cfg_wr(3'd2, 16'd12);
    cfg_wr(3'd3, 16'd1);
    cfg_wr(3'd4, 16'd0);
    for (int t = 0; t < 20 && !bus_oe_o; t++) tick();
    repeat (10) tick();
    @(posedge clk);
    hold = 1'b1;
    tick();
    chk("R8 bus floated on ack loss", bus_oe_o, 0);
    chk("R8 strobes idle on ack loss", {mreq_n_o, rd_n_o, wr_n_o}, 3'b111);
    chk("R8 request held during pause", busreq_n_o, 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      if (bus_oe_o || !mreq_n_o) quiet_bad++;
    end
    chk("R8 bus stays quiet while paused", quiet_bad, 0);
    @(posedge clk);
    hold = 1'b0;
    for (int t = 0; t < 500 && !done_o; t++) tick();
    chk("R8 copy completes after resume", done_o, 1);
    verify("R8 data intact across pause", 16'h0800, 16'h0900, 12, 1'b0);
  endtask

  task automatic t_refresh();
    int o, b, f, r;
    run_copy(16'h0A00, 16'h0B00, 200, 3'b010, o, b, f, r);
    chk("R9 refresh burst inserted", int'(b >= 1), 1);
    chk("R9 burst rows and length", r, 0);
    chk("R9 burst not before deadline", int'(f >= 600), 1);
    chk("R9 owned clocks equal copy plus bursts", o, 200 * 8 + b * 128);
    verify("R9 data intact around refresh", 16'h0A00, 16'h0B00, 200, 1'b0);
  endtask

  task automatic t_no_refresh();
    int o, b, f, r;
    run_copy(16'h0000, 16'h0C00, 300, 3'b000, o, b, f, r);
    chk("R10 sequential sweeps avoid refresh", b, 0);
    chk("R10 owned clocks", o, 1200);
    verify("R10 long copy data", 16'h0000, 16'h0C00, 300, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_zero();
    t_shape(2'b00, 2, "R4 2-clock cycle shape");
    t_shape(2'b01, 3, "R4 3-clock cycle shape");
    t_shape(2'b10, 4, "R4 4-clock cycle shape");
    t_shape(2'b11, 4, "R4 code 11 gives 4-clock cycle");
    t_rate();
    t_desc();
    t_busy_ignore();
    t_pause();
    t_refresh();
    t_no_refresh();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule